// File: doc/BRIEF.md
# UART Receive Engine with Error-Gated DMA Request

This block turns an asynchronous serial line into bytes. It receives frames of one start bit, eight data bits sent least significant bit first, and one stop bit. A sample tick runs at sixteen times the bit rate. That tick comes from a divider with an integer part and a four-bit fraction, so rates that are not a whole number of clocks per tick still average out correctly. Each received byte goes into a single holding register, and a full flag marks that register as unread. Software, or a DMA engine, empties it with a read strobe.

Three faults are reported as sticky flags: noise, a bad stop bit, and overrun. A write-one-to-clear strobe clears all three. Three settings change how the block reacts. The first picks either a three-sample majority vote, which can detect noise, or a single sample at mid-bit, which cannot. The second turns overrun detection on or off. The third chooses between two ways of handling a byte that arrives with an error: the byte can be dropped, or it can be kept while the DMA request is held back until software clears the error. These settings and the divider are captured only while the receiver is disabled.

Top module: `uart_rx_err`

## Requirements
- R1: After reset, rxFull, noiseErr, frameErr, overrunErr and dmaReq are all 0.
- R2: With divFrac = 0, one tick lasts divInt clocks and one bit lasts 16 ticks. A frame is low start, eight data bits LSB first, then a stop bit. The received byte appears on rxData and rxFull goes to 1 before the stop bit ends.
- R3: With a fraction f, the tick period averages divInt + f/16 clocks. A frame whose bits are 16·(divInt + f/16) clocks long is received without error.
- R4: With majority sampling selected (cfgSingleSample = 0), each bit is taken from three samples on consecutive ticks at 7, 8 and 9 ticks into the bit, and the bit value is the majority. If any bit of a frame (start, data or stop) has samples that disagree, noiseErr is set.
- R5: With cfgSingleSample = 1, each bit is taken from the single tick-8 sample and noiseErr is never set.
- R6: A stop bit that is sampled low sets frameErr.
- R7: With cfgOvrDetectOff = 0, a frame that completes while rxFull = 1, with no read in the same cycle, sets overrunErr. The unread byte is kept and the new byte is lost.
- R8: With cfgOvrDetectOff = 1, a frame that completes while rxFull = 1 replaces the unread byte, and overrunErr stays 0.
- R9: With cfgDmaMaskOnErr = 0, a frame with a noise or framing error sets its flag, leaves rxFull and rxData unchanged, and so raises no DMA request.
- R10: With cfgDmaMaskOnErr = 1, a frame with a noise or framing error is loaded and sets rxFull. dmaReq stays 0 until noiseErr and frameErr are both cleared.
- R11: dmaReq is 1 exactly when rxFull and dmaRxEn are both 1 and the request is not masked under R10.
- R12: rdStrobe clears rxFull on the next edge. errClrStrobe clears noiseErr, frameErr and overrunErr on the next edge. A frame completing in the same cycle takes priority over either strobe.
- R13: The three configuration inputs, divInt and divFrac are captured only while enable = 0. Changes while enable = 1 have no effect until the next disabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver on. While it is 0 the engine idles and configuration is captured |
| cfgSingleSample | input | 1 | 1 = one mid-bit sample, 0 = three-sample majority with noise detection |
| cfgOvrDetectOff | input | 1 | 1 = new byte overwrites an unread one, with no overrun flag |
| cfgDmaMaskOnErr | input | 1 | 1 = load errored bytes and mask DMA until the error flags are cleared |
| divInt | input | DIV_INT_W | Integer clocks per sample tick |
| divFrac | input | DIV_FRAC_W | Sixteenths of a clock added to each tick period |
| dmaRxEn | input | 1 | Allows the DMA request |
| rxIn | input | 1 | Serial receive line, idle high |
| rdStrobe | input | 1 | Buffer read. Clears rxFull |
| errClrStrobe | input | 1 | Clears all three error flags |
| rxData | output | DATA_W | Received byte |
| rxFull | output | 1 | Holding register contains an unread byte |
| noiseErr | output | 1 | Sticky noise flag |
| frameErr | output | 1 | Sticky bad-stop-bit flag |
| overrunErr | output | 1 | Sticky overrun flag |
| dmaReq | output | 1 | DMA receive request |

## Verification
The stop bit is judged at the ninth tick of the stop bit. The input passes through two synchronizer flops first, and start detection can lag by up to one tick. Even so, every flag, rxFull and rxData are settled well before the stop bit ends. The bench therefore checks results two clocks after it finishes driving the stop bit.

rdStrobe and errClrStrobe act on the next edge. dmaReq is a plain combination of registered state, so it follows dmaRxEn in the same cycle. The bench samples these one clock after a strobe, at the falling edge.

The noise glitches last exactly one tick. Because the samples are one tick apart, such a glitch always flips exactly one of the three majority samples, wherever the start was detected.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  // configuration captured while the receiver is disabled
  typedef struct packed {
    logic singleSmp;
    logic ovrOff;
    logic maskOnErr;
  } rxCfg_t;

  // control -> datapath strobes, each valid for one clock on a tick
  typedef struct packed {
    logic frameStart;
    logic smpA;
    logic smpB;
    logic evalStart;
    logic shift;
    logic finish;
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      tick,
  input  logic      lineLvl,
  input  logic      bitNow,
  output rxStrobe_t strb
);

  localparam int PH_W  = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0] SMP_A = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] SMP_B = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] EVAL  = PH_W'(OVS / 2 + 1);
  localparam logic [PH_W-1:0] LAST  = PH_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

  rxState_e         state;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strb = '0;
    if (tick) begin
      if (state == RX_IDLE) begin
        strb.frameStart = !lineLvl;
      end else begin
        strb.smpA = (phase == SMP_A);
        strb.smpB = (phase == SMP_B);
        if (phase == EVAL) begin
          strb.evalStart = (state == RX_START);
          strb.shift     = (state == RX_DATA);
          strb.finish    = (state == RX_STOP);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!enable) begin
      state  <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (!lineLvl) begin
            state <= RX_START;
            phase <= PH_W'(1);
          end
        end
        RX_START: begin
          if (phase == EVAL && bitNow) begin
            state <= RX_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
            if (phase == LAST) begin
              state  <= RX_DATA;
              bitIdx <= '0;
            end
          end
        end
        RX_DATA: begin
          phase <= phase + 1'b1;
          if (phase == LAST) begin
            if (bitIdx == LAST_BIT) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        RX_STOP: begin
          if (phase == EVAL) begin
            state <= RX_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_INT_W   = 12,
  parameter int DIV_FRAC_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  rxCfg_t                cfg,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic                  rxIn,
  input  logic                  dmaRxEn,
  input  logic                  rdStrobe,
  input  logic                  errClrStrobe,
  input  rxStrobe_t             strb,
  output logic                  tick,
  output logic                  lineLvl,
  output logic                  bitNow,
  output logic [DATA_W-1:0]     rxData,
  output logic                  rxFull,
  output logic                  noiseErr,
  output logic                  frameErr,
  output logic                  overrunErr,
  output logic                  dmaReq
);

  localparam int CNT_W = DIV_INT_W + 1;

  // ---------------- fractional tick generator ----------------
  logic [CNT_W-1:0]      tickCnt;
  logic [DIV_FRAC_W-1:0] fracAcc;
  logic [DIV_FRAC_W:0]   accSum;
  logic [CNT_W-1:0]      periodLen;
  logic [CNT_W-1:0]      reloadVal;

  assign accSum    = {1'b0, fracAcc} + {1'b0, divFrac};
  assign periodLen = {1'b0, divInt} + CNT_W'(accSum[DIV_FRAC_W]);
  assign reloadVal = (periodLen == '0) ? '0 : periodLen - 1'b1;
  assign tick      = enable && (tickCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      fracAcc <= '0;
    end else if (!enable) begin
      tickCnt <= '0;
      fracAcc <= '0;
    end else if (tick) begin
      tickCnt <= reloadVal;
      fracAcc <= accSum[DIV_FRAC_W-1:0];
    end else begin
      tickCnt <= tickCnt - 1'b1;
    end
  end

  // ---------------- input synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= rxIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b1;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign lineLvl = syncQ[SYNC_STAGES-1];

  // ---------------- bit sampling ----------------
  logic smpA;
  logic smpB;
  logic majVal;
  logic noiseNow;
  logic noiseAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpA <= 1'b1;
      smpB <= 1'b1;
    end else begin
      if (strb.smpA) smpA <= lineLvl;
      if (strb.smpB) smpB <= lineLvl;
    end
  end

  assign majVal   = (smpA & smpB) | (smpA & lineLvl) | (smpB & lineLvl);
  assign bitNow   = cfg.singleSmp ? smpB : majVal;
  assign noiseNow = !cfg.singleSmp && !((smpA == smpB) && (smpB == lineLvl));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      noiseAcc <= 1'b0;
    end else if (strb.frameStart) begin
      noiseAcc <= 1'b0;
    end else if (strb.evalStart || strb.shift) begin
      noiseAcc <= noiseAcc | noiseNow;
    end
  end

  // ---------------- deserializer ----------------
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.shift) shReg <= {bitNow, shReg[DATA_W-1:1]};
  end

  // ---------------- frame completion ----------------
  logic noiseHit;
  logic frameHit;
  logic errHit;
  logic blockNew;
  logic acceptNew;

  assign noiseHit  = strb.finish && (noiseAcc || noiseNow);
  assign frameHit  = strb.finish && !bitNow;
  assign errHit    = noiseHit || frameHit;
  assign blockNew  = rxFull && !rdStrobe && !cfg.ovrOff;
  assign acceptNew = strb.finish && !blockNew && (!errHit || cfg.maskOnErr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxFull <= 1'b0;
    end else if (acceptNew) begin
      rxData <= shReg;
      rxFull <= 1'b1;
    end else if (rdStrobe) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      noiseErr   <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (noiseHit)          noiseErr <= 1'b1;
      else if (errClrStrobe) noiseErr <= 1'b0;
      if (frameHit)          frameErr <= 1'b1;
      else if (errClrStrobe) frameErr <= 1'b0;
      if (strb.finish && blockNew) overrunErr <= 1'b1;
      else if (errClrStrobe)       overrunErr <= 1'b0;
    end
  end

  assign dmaReq = rxFull && dmaRxEn && !(cfg.maskOnErr && (noiseErr || frameErr));

endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_INT_W   = 12,
  parameter int DIV_FRAC_W  = 4,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  cfgSingleSample,
  input  logic                  cfgOvrDetectOff,
  input  logic                  cfgDmaMaskOnErr,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic                  dmaRxEn,
  input  logic                  rxIn,
  input  logic                  rdStrobe,
  input  logic                  errClrStrobe,
  output logic [DATA_W-1:0]     rxData,
  output logic                  rxFull,
  output logic                  noiseErr,
  output logic                  frameErr,
  output logic                  overrunErr,
  output logic                  dmaReq
);

  rxCfg_t                cfgQ;
  logic [DIV_INT_W-1:0]  divIntQ;
  logic [DIV_FRAC_W-1:0] divFracQ;
  rxStrobe_t             strb;
  logic                  tick;
  logic                  lineLvl;
  logic                  bitNow;

  // settings follow the inputs only while the receiver is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      divIntQ  <= '0;
      divFracQ <= '0;
    end else if (!enable) begin
      cfgQ     <= '{singleSmp: cfgSingleSample, ovrOff: cfgOvrDetectOff,
                    maskOnErr: cfgDmaMaskOnErr};
      divIntQ  <= divInt;
      divFracQ <= divFrac;
    end
  end

  uart_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .tick    (tick),
    .lineLvl (lineLvl),
    .bitNow  (bitNow),
    .strb    (strb)
  );

  uart_rx_dp #(
    .DATA_W      (DATA_W),
    .DIV_INT_W   (DIV_INT_W),
    .DIV_FRAC_W  (DIV_FRAC_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .cfg          (cfgQ),
    .divInt       (divIntQ),
    .divFrac      (divFracQ),
    .rxIn         (rxIn),
    .dmaRxEn      (dmaRxEn),
    .rdStrobe     (rdStrobe),
    .errClrStrobe (errClrStrobe),
    .strb         (strb),
    .tick         (tick),
    .lineLvl      (lineLvl),
    .bitNow       (bitNow),
    .rxData       (rxData),
    .rxFull       (rxFull),
    .noiseErr     (noiseErr),
    .frameErr     (frameErr),
    .overrunErr   (overrunErr),
    .dmaReq       (dmaReq)
  );

endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              dmaRxEn,
  input logic              rdStrobe,
  input logic              errClrStrobe,
  input logic              finishStb,
  input logic [2:0]        cfgBits,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              noiseErr,
  input logic              frameErr,
  input logic              overrunErr,
  input logic              dmaReq
);

  // R11
  dma_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (rxFull && dmaRxEn));

  // R10
  dma_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBits[0] && (noiseErr || frameErr)) |-> !dmaReq);

  // R12
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !finishStb) |=> !rxFull);

  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errClrStrobe && !finishStb) |=> (!noiseErr && !frameErr && !overrunErr));

  // R7
  ovr_from_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(finishStb));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !finishStb |=> $stable(rxData));

  // R5
  single_no_noise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finishStb && cfgBits[2]) |=> !$rose(noiseErr));

  // R13
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(cfgBits));

endmodule

bind uart_rx_err uart_rx_err_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .dmaRxEn      (dmaRxEn),
  .rdStrobe     (rdStrobe),
  .errClrStrobe (errClrStrobe),
  .finishStb    (strb.finish),
  .cfgBits      (cfgQ),
  .rxData       (rxData),
  .rxFull       (rxFull),
  .noiseErr     (noiseErr),
  .frameErr     (frameErr),
  .overrunErr   (overrunErr),
  .dmaReq       (dmaReq)
);

// File: tb/uart_rx_err_tb_top.sv
module uart_rx_err_tb_top;

  localparam int BIT8 = 128;  // divInt 8 -> 16 ticks of 8 clocks

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgSingleSample = 1'b0;
  logic        cfgOvrDetectOff = 1'b0;
  logic        cfgDmaMaskOnErr = 1'b0;
  logic [11:0] divInt = 12'd8;
  logic [3:0]  divFrac = 4'd0;
  logic        dmaRxEn = 1'b0;
  logic        rxIn = 1'b1;
  logic        rdStrobe = 1'b0;
  logic        errClrStrobe = 1'b0;
  logic [7:0]  rxData;
  logic        rxFull;
  logic        noiseErr;
  logic        frameErr;
  logic        overrunErr;
  logic        dmaReq;

  int vecs = 0;
  int miscomp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_err dut_i (
    .clk             (clk),
    .rstN            (rstN),
    .enable          (enable),
    .cfgSingleSample (cfgSingleSample),
    .cfgOvrDetectOff (cfgOvrDetectOff),
    .cfgDmaMaskOnErr (cfgDmaMaskOnErr),
    .divInt          (divInt),
    .divFrac         (divFrac),
    .dmaRxEn         (dmaRxEn),
    .rxIn            (rxIn),
    .rdStrobe        (rdStrobe),
    .errClrStrobe    (errClrStrobe),
    .rxData          (rxData),
    .rxFull          (rxFull),
    .noiseErr        (noiseErr),
    .frameErr        (frameErr),
    .overrunErr      (overrunErr),
    .dmaReq          (dmaReq)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // frame: index 0 start, 1..8 data LSB first, 9 stop
  task automatic sendFrame(input logic [7:0] b, input int bitClk, input logic stopLvl,
                           input int gBit, input int gOff, input int gLen);
    for (int i = 0; i < 10; i++) begin
      logic lvl;
      lvl = (i == 0) ? 1'b0 : ((i == 9) ? stopLvl : b[i-1]);
      rxIn = lvl;
      if (i == gBit) begin
        waitClk(gOff);
        rxIn = ~lvl;
        waitClk(gLen);
        rxIn = lvl;
        waitClk(bitClk - gOff - gLen);
      end else begin
        waitClk(bitClk);
      end
    end
    rxIn = 1'b1;
    waitClk(2);
  endtask

  task automatic setup(input logic single, input logic ovrOff, input logic mask,
                       input int dInt, input int dFrac);
    enable = 1'b0;
    waitClk(2);
    cfgSingleSample = single;
    cfgOvrDetectOff = ovrOff;
    cfgDmaMaskOnErr = mask;
    divInt  = 12'(dInt);
    divFrac = 4'(dFrac);
    waitClk(2);
    enable = 1'b1;
    waitClk(2);
  endtask

  task automatic pulseRd();
    rdStrobe = 1'b1;
    waitClk(1);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseClr();
    errClrStrobe = 1'b1;
    waitClk(1);
    errClrStrobe = 1'b0;
  endtask

  task automatic clearAll();
    rdStrobe = 1'b1;
    errClrStrobe = 1'b1;
    waitClk(1);
    rdStrobe = 1'b0;
    errClrStrobe = 1'b0;
    waitClk(1);
  endtask

  task automatic testReset();
    check("R1 rxFull", int'(rxFull), 0);
    check("R1 noiseErr", int'(noiseErr), 0);
    check("R1 frameErr", int'(frameErr), 0);
    check("R1 overrunErr", int'(overrunErr), 0);
    check("R1 dmaReq", int'(dmaReq), 0);
  endtask

  task automatic testBasic();
    setup(1'b0, 1'b0, 1'b0, 8, 0);
    dmaRxEn = 1'b1;
    clearAll();
    sendFrame(8'hA5, BIT8, 1'b1, -1, 0, 0);
    check("R2 rxData", int'(rxData), 'hA5);
    check("R2 rxFull", int'(rxFull), 1);
    check("R2 noiseErr", int'(noiseErr), 0);
    check("R2 frameErr", int'(frameErr), 0);
    check("R11 dmaReq on", int'(dmaReq), 1);
    dmaRxEn = 1'b0;
    waitClk(1);
    check("R11 dmaReq gated", int'(dmaReq), 0);
    dmaRxEn = 1'b1;
    waitClk(1);
    pulseRd();
    check("R12 read clears rxFull", int'(rxFull), 0);
    check("R11 dmaReq after read", int'(dmaReq), 0);
  endtask

  task automatic testOverrun();
    setup(1'b0, 1'b0, 1'b0, 8, 0);
    clearAll();
    sendFrame(8'h3C, BIT8, 1'b1, -1, 0, 0);
    waitClk(BIT8);
    sendFrame(8'hC3, BIT8, 1'b1, -1, 0, 0);
    check("R7 overrunErr", int'(overrunErr), 1);
    check("R7 old byte kept", int'(rxData), 'h3C);
    check("R7 rxFull", int'(rxFull), 1);
    pulseClr();
    check("R12 clear overrun", int'(overrunErr), 0);
  endtask

  task automatic testOverwrite();
    setup(1'b0, 1'b1, 1'b0, 8, 0);
    clearAll();
    sendFrame(8'h3C, BIT8, 1'b1, -1, 0, 0);
    waitClk(BIT8);
    sendFrame(8'hC3, BIT8, 1'b1, -1, 0, 0);
    check("R8 overrunErr stays 0", int'(overrunErr), 0);
    check("R8 newest byte", int'(rxData), 'hC3);
  endtask

  task automatic testNoiseDrop();
    setup(1'b0, 1'b0, 1'b0, 8, 0);
    clearAll();
    sendFrame(8'h5A, BIT8, 1'b1, 4, 66, 8);
    check("R4 noiseErr", int'(noiseErr), 1);
    check("R4 frameErr", int'(frameErr), 0);
    check("R9 rxFull unchanged", int'(rxFull), 0);
    check("R9 rxData unchanged", int'(rxData), 'hC3);
    check("R9 no dmaReq", int'(dmaReq), 0);
  endtask

  task automatic testNoiseMask();
    setup(1'b0, 1'b0, 1'b1, 8, 0);
    clearAll();
    sendFrame(8'h5A, BIT8, 1'b1, 4, 66, 8);
    check("R4 noiseErr masked mode", int'(noiseErr), 1);
    check("R4 majority data", int'(rxData), 'h5A);
    check("R10 rxFull", int'(rxFull), 1);
    check("R10 dmaReq masked", int'(dmaReq), 0);
    pulseClr();
    check("R10 dmaReq released", int'(dmaReq), 1);
  endtask

  task automatic testSingle();
    setup(1'b1, 1'b0, 1'b0, 8, 0);
    clearAll();
    sendFrame(8'h5A, BIT8, 1'b1, 4, 66, 8);
    check("R5 noiseErr off", int'(noiseErr), 0);
    check("R5 rxFull", int'(rxFull), 1);
  endtask

  task automatic testFrame();
    setup(1'b0, 1'b0, 1'b0, 8, 0);
    clearAll();
    sendFrame(8'h81, BIT8, 1'b0, -1, 0, 0);
    check("R6 frameErr", int'(frameErr), 1);
    check("R6 noiseErr", int'(noiseErr), 0);
    check("R9 framed byte dropped", int'(rxFull), 0);
    waitClk(2 * BIT8);
  endtask

  task automatic testFrac();
    setup(1'b0, 1'b0, 1'b0, 4, 8);
    clearAll();
    sendFrame(8'h6E, 72, 1'b1, -1, 0, 0);
    check("R3 fractional data", int'(rxData), 'h6E);
    check("R3 rxFull", int'(rxFull), 1);
    check("R3 no noise", int'(noiseErr), 0);
    check("R3 no frame error", int'(frameErr), 0);
  endtask

  task automatic testLock();
    setup(1'b0, 1'b0, 1'b0, 8, 0);
    clearAll();
    cfgOvrDetectOff = 1'b1;
    divInt = 12'd4;
    waitClk(2);
    sendFrame(8'h3C, BIT8, 1'b1, -1, 0, 0);
    waitClk(BIT8);
    sendFrame(8'hC3, BIT8, 1'b1, -1, 0, 0);
    check("R13 overrun still detected", int'(overrunErr), 1);
    check("R13 first byte kept", int'(rxData), 'h3C);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    testReset();
    testBasic();
    testOverrun();
    testOverwrite();
    testNoiseDrop();
    testNoiseMask();
    testSingle();
    testFrame();
    testFrac();
    testLock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscomp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++;
      miscomp++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miscomp);
      $finish;
    end
  end

endmodule